// File: doc/BRIEF.md
# Two-Stage Reloadable Down-Counter with Pulse Output and Edge Interrupt

The block chains an 8-bit prescaler in front of an 8-bit timer. Both stages count downward. Each stage has a reload latch that software writes over a small register bus. A stage reaches zero, and then the next count pulse makes it underflow. On that underflow it reloads from its latch and keeps counting. A latch value of n therefore divides the stage's count source by n+1. Each underflow produces a one-cycle interrupt request.

The timer has two possible count sources: the system clock or the prescaler's underflow. A pulse-output mode makes every timer underflow toggle an output pin, and the same mode bit drives the pin's output enable. A separate detector watches an external counter input through a two-flop synchronizer. It raises a one-cycle interrupt on each rising or falling edge, depending on a control bit.

Register map, written through `wr_*` and read combinationally through `rd_addr`/`rd_data`:

| Address | Write | Read |
|---------|-------|------|
| 0 | prescaler latch | live prescaler count |
| 1 | timer latch | live timer count |
| 2 | control byte | control byte |
| 3 | ignored | 0 |

The control byte has four used bits:

| Bit | Name | Meaning |
|-----|------|---------|
| 0 | halt | 1 = both stages frozen |
| 1 | source select | 0 = system clock, 1 = prescaler underflow |
| 2 | pulse-output mode | 1 = mode on |
| 3 | edge select | 0 = rising, 1 = falling |

Bits 7:4 are spare storage.

Top module: `dual_downtimer`

## Requirements
- R1: After reset, both latches and both counters hold 0xFF and the control byte is 0x01 (halted). All interrupt outputs, `pulse_out` and `pulse_oe` are 0.
- R2: While running, the prescaler decrements on every clock. With latch n it underflows once every n+1 clocks, and n=0 gives an underflow on every clock.
- R3: With control bit 1 = 0 the timer counts on every clock. With bit 1 = 1 it counts only on prescaler underflows, so latches p and t give a timer underflow every (p+1)(t+1) clocks.
- R4: A stage that holds zero underflows on its next count pulse. It then loads its latch value and keeps counting without stopping. A count pulse on a nonzero value decrements it by one.
- R5: `pre_irq` and `tmr_irq` are high for exactly the one cycle after each underflow of their stage.
- R6: A latch write while halted also loads that counter on the same edge. A latch write while running changes only the latch, and the new value takes effect at the next reload.
- R7: While control bit 0 = 1, both counters hold their values, and reads of addresses 0 and 1 return the live counts.
- R8: With control bit 2 = 1, each timer underflow toggles `pulse_out`. A write that sets bit 2 while it was 0 clears `pulse_out` to 0. `pulse_oe` equals bit 2.
- R9: `ext_cnt_in` passes through two synchronizer flops. A rising edge (control bit 3 = 0) or a falling edge (bit 3 = 1) makes `edge_irq` high for one cycle, three clock edges after the input changes.
- R10: Reads follow the address map: 0 = prescaler count, 1 = timer count, 2 = control byte, 3 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| ext_cnt_in | input | 1 | External counter input (asynchronous) |
| pre_irq | output | 1 | Prescaler underflow request pulse |
| tmr_irq | output | 1 | Timer underflow request pulse |
| edge_irq | output | 1 | External edge request pulse |
| pulse_out | output | 1 | Toggle output of the pulse mode |
| pulse_oe | output | 1 | Output enable for `pulse_out` |

## Verification
Each result has a fixed latency:

- Counter values, latch writes and the control byte become visible on the edge that follows the tick or write.
- `pulse_out` toggles on the same edge as the reload.
- `pre_irq` and `tmr_irq` follow one edge after the underflow.
- `edge_irq` follows three edges after a change on `ext_cnt_in`.

A behavioural model in the bench updates on each rising edge with exactly these latencies. Every output is compared against it 1 ns after that edge, while the bus inputs change only on falling edges. Directed phases measure the cascaded period, halted and running latch writes, freezing, re-entry into pulse mode, a zero prescaler latch and both edge polarities.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [1:0] {
    REG_PRE  = 2'd0,
    REG_TMR  = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [3:0] spare;
    logic       edge_fall;
    logic       pulse_en;
    logic       src_pre;
    logic       halt;
  } ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h01;
  localparam int NUM_STAGES = 2;
  localparam int STG_PRE = 0;
  localparam int STG_TMR = 1;
endpackage

// File: rtl/dt_stage.sv
module dt_stage #(
  parameter int CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             wr_latch,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             uf;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rl);
    if (cur == '0) next_count = rl;
    else           next_count = cur - 1'b1;
  endfunction

  assign uf = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= RST_VAL;
      cnt_q   <= RST_VAL;
      irq_q   <= 1'b0;
    end else begin
      if (wr_latch) latch_q <= wdata;
      if (load)      cnt_q <= wdata;
      else if (tick) cnt_q <= next_count(cnt_q, latch_q);
      irq_q <= uf;
    end
  end

  assign cnt_o = cnt_q;
  assign uf_o  = uf;
  assign irq_o = irq_q;

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> cnt_q == $past(latch_q));
  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  assert_direct_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(wdata));
  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> irq_o);
  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !uf |=> !irq_o);
endmodule

// File: rtl/dt_edge.sv
module dt_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   irq_q;
  logic                   rise_ev;
  logic                   fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= pin;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= sync_q[i-1];
    end
  end

  assign rise_ev = sync_q[SYNC_STAGES-1] && !prev_q;
  assign fall_ev = !sync_q[SYNC_STAGES-1] && prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      irq_q  <= fall_sel ? fall_ev : rise_ev;
    end
  end

  assign irq_o = irq_q;

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  assert_rise_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_sel && !rise_ev) |=> !irq_o);
endmodule

// File: rtl/dt_pulse.sv
module dt_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic mode_enter,
  input  logic uf,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulse_q <= 1'b0;
    else if (mode_enter)       pulse_q <= 1'b0;
    else if (mode_en && uf)    pulse_q <= ~pulse_q;
  end

  assign pulse_o = pulse_q;

  assert_enter_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_enter |=> !pulse_o);
  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && uf && !mode_enter) |=> pulse_o != $past(pulse_o));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf && !mode_enter) |=> $stable(pulse_o));
endmodule

// File: rtl/dt_regs.sv
module dt_regs
  import dt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic [CNT_W-1:0]  pre_cnt,
  input  logic [CNT_W-1:0]  tmr_cnt,
  output ctl_t              ctl_o,
  output logic              pre_wr,
  output logic              tmr_wr,
  output logic              pulse_enter,
  output logic [DATA_W-1:0] rd_data
);
  ctl_t ctl_q;
  ctl_t ctl_wr;
  logic ctl_wr_en;

  assign ctl_wr     = ctl_t'(wr_data[7:0]);
  assign pre_wr     = wr_en && (reg_sel_e'(wr_addr) == REG_PRE);
  assign tmr_wr     = wr_en && (reg_sel_e'(wr_addr) == REG_TMR);
  assign ctl_wr_en  = wr_en && (reg_sel_e'(wr_addr) == REG_CTL);
  assign pulse_enter = ctl_wr_en && ctl_wr.pulse_en && !ctl_q.pulse_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl_q <= ctl_t'(CTL_RESET);
    else if (ctl_wr_en) ctl_q <= ctl_wr;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      REG_PRE: rd_data = DATA_W'(pre_cnt);
      REG_TMR: rd_data = DATA_W'(tmr_cnt);
      REG_CTL: rd_data = DATA_W'(ctl_q);
      default: rd_data = '0;
    endcase
  end

  assign ctl_o = ctl_q;

  assert_ctl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> ctl_o == $past(ctl_wr));
  assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr_en |=> $stable(ctl_o));
endmodule

// File: rtl/dual_downtimer.sv
module dual_downtimer
  import dt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_cnt_in,
  output logic              pre_irq,
  output logic              tmr_irq,
  output logic              edge_irq,
  output logic              pulse_out,
  output logic              pulse_oe
);
  ctl_t ctl;
  logic pre_wr, tmr_wr, pulse_enter;
  logic running;
  logic [NUM_STAGES-1:0] stg_tick;
  logic [NUM_STAGES-1:0] stg_load;
  logic [NUM_STAGES-1:0] stg_wr;
  logic [NUM_STAGES-1:0] stg_uf;
  logic [NUM_STAGES-1:0] stg_irq;
  logic [CNT_W-1:0]      stg_cnt [NUM_STAGES];

  dt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pre_cnt(stg_cnt[STG_PRE]), .tmr_cnt(stg_cnt[STG_TMR]),
    .ctl_o(ctl), .pre_wr(pre_wr), .tmr_wr(tmr_wr), .pulse_enter(pulse_enter),
    .rd_data(rd_data)
  );

  assign running            = !ctl.halt;
  assign stg_wr[STG_PRE]    = pre_wr;
  assign stg_wr[STG_TMR]    = tmr_wr;
  assign stg_tick[STG_PRE]  = running;
  assign stg_tick[STG_TMR]  = running && (ctl.src_pre ? stg_uf[STG_PRE] : 1'b1);

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign stg_load[s] = stg_wr[s] && ctl.halt;
    dt_stage #(.CNT_W(CNT_W), .RST_VAL('1)) u_stage (
      .clk(clk), .rst_n(rst_n), .tick(stg_tick[s]), .load(stg_load[s]),
      .wr_latch(stg_wr[s]), .wdata(wr_data[CNT_W-1:0]),
      .cnt_o(stg_cnt[s]), .uf_o(stg_uf[s]), .irq_o(stg_irq[s])
    );
  end

  dt_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .mode_en(ctl.pulse_en), .mode_enter(pulse_enter),
    .uf(stg_uf[STG_TMR]), .pulse_o(pulse_out)
  );

  dt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_cnt_in), .fall_sel(ctl.edge_fall),
    .irq_o(edge_irq)
  );

  assign pre_irq  = stg_irq[STG_PRE];
  assign tmr_irq  = stg_irq[STG_TMR];
  assign pulse_oe = ctl.pulse_en;

  assert_cascade_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.src_pre && stg_uf[STG_TMR]) |-> stg_uf[STG_PRE]);
  assert_halt_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.halt && $past(ctl.halt)) |-> !(pre_irq || tmr_irq));
endmodule

// File: tb/tb_dual_downtimer.sv
`timescale 1ns/1ps
module tb_dual_downtimer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       ext_cnt_in = 1'b0;
  logic       pre_irq, tmr_irq, edge_irq, pulse_out, pulse_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string phase = "R1";

  dual_downtimer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_cnt_in(ext_cnt_in),
    .pre_irq(pre_irq), .tmr_irq(tmr_irq), .edge_irq(edge_irq),
    .pulse_out(pulse_out), .pulse_oe(pulse_oe)
  );

  always #2 clk = ~clk;

  // reference model state
  int m_pl, m_tl, m_pc, m_tc;
  logic [7:0] m_ctl;
  bit m_pff, m_pirq, m_tirq, m_eirq, m_s1, m_s2, m_s3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pl = 255; m_tl = 255; m_pc = 255; m_tc = 255; m_ctl = 8'h01;
      m_pff = 0; m_pirq = 0; m_tirq = 0; m_eirq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit run, puf, ttick, tuf, wp, wt, wc;
      cyc++;
      run   = !m_ctl[0];
      puf   = run && (m_pc == 0);
      ttick = run && (m_ctl[1] ? puf : 1'b1);
      tuf   = ttick && (m_tc == 0);
      wp = wr_en && wr_addr == 2'd0;
      wt = wr_en && wr_addr == 2'd1;
      wc = wr_en && wr_addr == 2'd2;
      if (wp && !run) m_pc = wr_data;
      else if (run)   m_pc = (m_pc == 0) ? m_pl : m_pc - 1;
      if (wt && !run) m_tc = wr_data;
      else if (ttick) m_tc = (m_tc == 0) ? m_tl : m_tc - 1;
      if (wp) m_pl = wr_data;
      if (wt) m_tl = wr_data;
      if (wc && wr_data[2] && !m_ctl[2]) m_pff = 0;
      else if (m_ctl[2] && tuf)          m_pff = !m_pff;
      m_eirq = m_ctl[3] ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_cnt_in;
      m_pirq = puf;
      m_tirq = tuf;
      if (wc) m_ctl = wr_data;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) actual=%0h expected=%0h at cycle %0d", tag, phase, act, exp, cyc);
    end
  endtask

  // compare every clock, 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      int exp_rd;
      case (rd_addr)
        2'd0: exp_rd = m_pc;
        2'd1: exp_rd = m_tc;
        2'd2: exp_rd = m_ctl;
        default: exp_rd = 0;
      endcase
      chk(rd_data, exp_rd, rd_addr == 2'd0 ? "R2" : rd_addr == 2'd1 ? "R4" : "R10");
      chk(pre_irq,  m_pirq, "R5");
      chk(tmr_irq,  m_tirq, "R5");
      chk(pulse_out, m_pff, "R8");
      chk(pulse_oe, m_ctl[2], "R8");
      chk(edge_irq, m_eirq, "R9");
    end
  end

  always @(negedge clk) rd_addr <= rd_addr + 2'd1;

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    #3;
    // R1: outputs during reset
    chk(pre_irq, 0, "R1"); chk(tmr_irq, 0, "R1"); chk(edge_irq, 0, "R1");
    chk(pulse_out, 0, "R1"); chk(pulse_oe, 0, "R1");
    idle(3);
    rst_n = 1'b1;
    phase = "R1"; idle(6);

    phase = "R6"; bus_wr(2'd0, 8'd3); bus_wr(2'd1, 8'd2); idle(6);

    phase = "R4"; bus_wr(2'd2, 8'h00); idle(30);

    phase = "R3"; bus_wr(2'd2, 8'h06);
    @(posedge tmr_irq);
    @(posedge tmr_irq); t0 = cyc;
    @(posedge tmr_irq);
    chk(cyc - t0, 12, "R3");

    phase = "R6"; bus_wr(2'd1, 8'd5); idle(60);

    phase = "R7"; bus_wr(2'd2, 8'h07); idle(12);

    phase = "R8"; bus_wr(2'd2, 8'h02); idle(10);
    bus_wr(2'd2, 8'h06);
    chk(pulse_out, 0, "R8");
    idle(40);

    phase = "R2"; bus_wr(2'd0, 8'd0); idle(40);

    phase = "R9"; bus_wr(2'd2, 8'h02);
    ext_cnt_in = 1'b1; idle(6);
    ext_cnt_in = 1'b0; idle(6);
    bus_wr(2'd2, 8'h0A);
    ext_cnt_in = 1'b1; idle(6);
    ext_cnt_in = 1'b0; idle(6);
    ext_cnt_in = 1'b1; idle(1);
    ext_cnt_in = 1'b0; idle(8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule